// File: doc/BRIEF.md
# Timer Compare-Match Unit

This block holds a 16-bit timer for a CAN controller, together with three compare registers that are matched against it. The timer advances by one on each cycle in which the tick input is high. Each compare register has an enable bit of its own. When that compare register equals the timer and its enable bit is set, a fixed sticky interrupt flag is set. Software clears a flag by writing one to its bit. An interrupt output is raised while any flag is set and not masked.

Compare register 0 can also reset the timer. When its clear control is set and the timer equals compare 0, the next tick loads zero instead of the incremented value. A 3-bit cycle-count-max field selects the operating mode. Any value other than 111 means time-triggered operation, and in that mode the clear path is forced off so that local time is never lost.

Software reaches all state through a small register port with a combinational read. The register map is: 0 is control, 1 to 3 are compare 0 to compare 2, 4 is the timer, 5 is the flags, and 6 is the mask. A write to the timer loads it directly.

Top module: `cmp_timer_unit`

## Requirements
- R1: After reset, the control register reads 0x0007 (all enables and the clear control at 0, mode field 111), and the timer, flags, mask and irq_o are all 0.
- R2: The timer increments by one on each cycle with tick_i high, holds its value without a tick, and wraps from 0xFFFF to 0x0000.
- R3: With control bit 12 set, a match between compare 2 and the timer sets flag bit 11.
- R4: With control bit 11 set, a match between compare 1 and the timer sets flag bit 15.
- R5: With control bit 10 set, a match between compare 0 and the timer sets flag bit 14.
- R6: A match whose enable bit is 0 sets no flag.
- R7: Control bits 9 to 7 always read as 0, whatever is written. Only bits 12, 11, 10 and 6 and the mode field in bits 2 to 0 are stored, so writing 0xFFFF reads back as 0x1C47.
- R8: With control bit 6 set and the mode field equal to 111, the tick after the timer has equalled compare 0 loads 0x0000 into the timer.
- R9: With the mode field not equal to 111, compare 0 never clears the timer, even with bit 6 set.
- R10: Flags are sticky. Writing 1 to a flag bit at address 5 clears it. A match in the same cycle as the clear wins, and the flag stays set.
- R11: irq_o is high exactly when some flag is set whose bit at the same position in the mask register (address 6) is 0.
- R12: A match is taken once per timer value: the first cycle after the timer is loaded or ticks to that value. While the timer holds that value, a cleared flag is not set again.
- R13: A write to address 4 loads the timer with the written data, and this takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer count enable |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rd_data_o | output | 16 | Combinational read data for addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that the timer holds without a tick and increments or wraps with one. They also check that a load takes effect and that the clear path is blocked in time-triggered mode. Further cycle checks cover the reserved control bits reading zero, flags staying set unless written, and irq_o staying low while no flag is set. Only the bench scenarios can show the following:
- which flag each compare register drives;
- that a match is taken just once per timer value;
- that a set beats a same-cycle clear;
- that the clear lands on the tick after the match.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int unsigned NUM_CMP   = 3;
  localparam int unsigned MODE_W    = 3;
  localparam logic [MODE_W-1:0] MODE_FREE = 3'b111;
  localparam int unsigned CLR_POS   = 6;

  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_CMP0 = 1;
  localparam int unsigned ADDR_CNT  = 4;
  localparam int unsigned ADDR_FLAG = 5;
  localparam int unsigned ADDR_MASK = 6;

  // enable bit position of compare k in the control word
  function automatic int unsigned en_pos(int unsigned k);
    return 10 + k;
  endfunction

  // fixed flag bit driven by compare k
  function automatic int unsigned flag_pos(int unsigned k);
    case (k)
      0:       return 14;
      1:       return 15;
      default: return 11;
    endcase
  endfunction
endpackage

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         zero_i,
  output logic [W-1:0] cnt_o,
  output logic         fresh_o
);
  logic [W-1:0] cnt_q;
  logic         fresh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fresh_q <= 1'b1;
    end else begin
      if (load_i)      cnt_q <= load_val_i;
      else if (tick_i) cnt_q <= zero_i ? '0 : cnt_q + W'(1);
      fresh_q <= load_i | tick_i;
    end
  end

  assign cnt_o   = cnt_q;
  assign fresh_o = fresh_q;
endmodule

// File: rtl/cmp_timer_match.sv
module cmp_timer_match #(
  parameter int unsigned W = 16,
  parameter int unsigned N = 3
) (
  input  logic [W-1:0]        cnt_i,
  input  logic                fresh_i,
  input  logic [N-1:0][W-1:0] cmp_i,
  output logic [N-1:0]        eq_o,
  output logic [N-1:0]        hit_o
);
  for (genvar k = 0; k < N; k++) begin : g_cmp
    assign eq_o[k]  = (cnt_i == cmp_i[k]);
    assign hit_o[k] = eq_o[k] & fresh_i;
  end
endmodule

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
  import cmp_timer_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned N  = 3,
  parameter int unsigned AW = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [W-1:0]        wdata_i,
  input  logic [W-1:0]        cnt_i,
  input  logic [N-1:0]        hit_i,
  output logic [W-1:0]        rd_data_o,
  output logic                load_o,
  output logic [N-1:0][W-1:0] cmp_o,
  output logic                clr_eff_o,
  output logic [MODE_W-1:0]   mode_o,
  output logic                clr_o,
  output logic [N-1:0]        flag_o,
  output logic [N-1:0]        mask_o
);
  logic [N-1:0]        en_q, flag_q, mask_q;
  logic                clr_q;
  logic [MODE_W-1:0]   mode_q;
  logic [N-1:0][W-1:0] cmp_q;
  logic wr_ctrl, wr_flag, wr_mask;

  assign wr_ctrl = wr_en_i && (addr_i == AW'(ADDR_CTRL));
  assign wr_flag = wr_en_i && (addr_i == AW'(ADDR_FLAG));
  assign wr_mask = wr_en_i && (addr_i == AW'(ADDR_MASK));
  assign load_o  = wr_en_i && (addr_i == AW'(ADDR_CNT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_q  <= 1'b0;
      mode_q <= MODE_FREE;
    end else if (wr_ctrl) begin
      clr_q  <= wdata_i[CLR_POS];
      mode_q <= wdata_i[MODE_W-1:0];
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_ch
    localparam int unsigned EP = en_pos(k);
    localparam int unsigned FP = flag_pos(k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[k]   <= 1'b0;
        cmp_q[k]  <= '0;
        flag_q[k] <= 1'b0;
        mask_q[k] <= 1'b0;
      end else begin
        if (wr_ctrl) en_q[k] <= wdata_i[EP];
        if (wr_en_i && (addr_i == AW'(ADDR_CMP0 + k))) cmp_q[k] <= wdata_i;
        if (wr_mask) mask_q[k] <= wdata_i[FP];
        // set wins over write-one-clear
        flag_q[k] <= (flag_q[k] & ~(wr_flag & wdata_i[FP])) | (en_q[k] & hit_i[k]);
      end
    end
  end

  assign clr_eff_o = clr_q && (mode_q == MODE_FREE);

  always_comb begin
    rd_data_o = '0;
    if (addr_i == AW'(ADDR_CTRL)) begin
      rd_data_o[MODE_W-1:0] = mode_q;
      rd_data_o[CLR_POS]    = clr_q;
      for (int k = 0; k < N; k++) rd_data_o[en_pos(k)] = en_q[k];
    end else if (addr_i == AW'(ADDR_CNT)) begin
      rd_data_o = cnt_i;
    end else if (addr_i == AW'(ADDR_FLAG)) begin
      for (int k = 0; k < N; k++) rd_data_o[flag_pos(k)] = flag_q[k];
    end else if (addr_i == AW'(ADDR_MASK)) begin
      for (int k = 0; k < N; k++) rd_data_o[flag_pos(k)] = mask_q[k];
    end else begin
      for (int k = 0; k < N; k++)
        if (addr_i == AW'(ADDR_CMP0 + k)) rd_data_o = cmp_q[k];
    end
  end

  assign cmp_o  = cmp_q;
  assign mode_o = mode_q;
  assign clr_o  = clr_q;
  assign flag_o = flag_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/cmp_timer_unit.sv
module cmp_timer_unit
  import cmp_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  localparam int unsigned N = NUM_CMP;

  logic [DATA_W-1:0]        cnt;
  logic                     fresh, load, clr_eff, clr_en;
  logic [MODE_W-1:0]        mode;
  logic [N-1:0][DATA_W-1:0] cmp;
  logic [N-1:0]             eq, hit, flg, msk;

  cmp_timer_counter #(.W(DATA_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (load),
    .load_val_i (wdata_i),
    .zero_i     (clr_eff & eq[0]),
    .cnt_o      (cnt),
    .fresh_o    (fresh)
  );

  cmp_timer_match #(.W(DATA_W), .N(N)) u_match (
    .cnt_i   (cnt),
    .fresh_i (fresh),
    .cmp_i   (cmp),
    .eq_o    (eq),
    .hit_o   (hit)
  );

  cmp_timer_regs #(.W(DATA_W), .N(N), .AW(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .cnt_i     (cnt),
    .hit_i     (hit),
    .rd_data_o (rd_data_o),
    .load_o    (load),
    .cmp_o     (cmp),
    .clr_eff_o (clr_eff),
    .mode_o    (mode),
    .clr_o     (clr_en),
    .flag_o    (flg),
    .mask_o    (msk)
  );

  assign irq_o = |(flg & ~msk);
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk
  import cmp_timer_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned N  = 3,
  parameter int unsigned AW = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic [AW-1:0]     addr_i,
  input logic [W-1:0]      wdata_i,
  input logic [W-1:0]      rd_data_o,
  input logic              irq_o,
  input logic [W-1:0]      cnt,
  input logic [W-1:0]      cmp0,
  input logic [MODE_W-1:0] mode,
  input logic [N-1:0]      flg
);
  logic wr_cnt, wr_flag;
  assign wr_cnt  = wr_en_i && (addr_i == AW'(ADDR_CNT));
  assign wr_flag = wr_en_i && (addr_i == AW'(ADDR_FLAG));

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_cnt) |=> (cnt == $past(cnt))); // R2
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_cnt && cnt != cmp0) |=> (cnt == W'($past(cnt) + W'(1)))); // R2
  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt |=> (cnt == $past(wdata_i))); // R13
  AST_CLR_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_cnt && mode != MODE_FREE) |=> (cnt == W'($past(cnt) + W'(1)))); // R9
  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == AW'(ADDR_CTRL)) |-> (rd_data_o[9:7] == 3'b000)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_flag) |=> ((flg & $past(flg)) == $past(flg))); // R10
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flg == '0) |-> !irq_o); // R11
endmodule

bind cmp_timer_unit cmp_timer_chk #(.W(DATA_W), .N(cmp_timer_pkg::NUM_CMP), .AW(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rd_data_o (rd_data_o),
  .irq_o     (irq_o),
  .cnt       (cnt),
  .cmp0      (cmp[0]),
  .mode      (mode),
  .flg       (flg)
);

// File: tb/cmp_timer_unit_test.sv
module cmp_timer_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = 3'd0;
  logic [15:0] wdata_i = 16'd0;
  logic [15:0] rd_data_o;
  logic        irq_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // behavioural model state
  int m_cnt = 0;
  bit m_fresh = 1;
  int m_ctrl = 16'h0007;
  int m_cmp [3] = '{0, 0, 0};
  bit m_flag [3] = '{0, 0, 0};
  bit m_mask [3] = '{0, 0, 0};
  int FPOS [3] = '{14, 15, 11};

  cmp_timer_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  function automatic int m_rd(input int a);
    int v = 0;
    case (a)
      0: v = m_ctrl;
      1, 2, 3: v = m_cmp[a-1];
      4: v = m_cnt;
      5: for (int k = 0; k < 3; k++) if (m_flag[k]) v |= (1 << FPOS[k]);
      6: for (int k = 0; k < 3; k++) if (m_mask[k]) v |= (1 << FPOS[k]);
      default: v = 0;
    endcase
    return v;
  endfunction

  function automatic bit m_irq();
    bit r = 0;
    for (int k = 0; k < 3; k++) if (m_flag[k] && !m_mask[k]) r = 1;
    return r;
  endfunction

  task automatic cyc(input bit t, input bit w, input int a, input int d);
    bit hit [3];
    bit clr_eff;
    int n_cnt;
    tick_i = t; wr_en_i = w; addr_i = 3'(a); wdata_i = 16'(d);
    @(posedge clk_i);
    for (int k = 0; k < 3; k++) hit[k] = m_fresh && (m_cnt == m_cmp[k]);
    clr_eff = m_ctrl[6] && (m_ctrl[2:0] == 3'b111);
    if (w && a == 4) n_cnt = d;
    else if (t) n_cnt = (clr_eff && m_cnt == m_cmp[0]) ? 0 : (m_cnt + 1) % 65536;
    else n_cnt = m_cnt;
    m_fresh = (w && a == 4) || t;
    for (int k = 0; k < 3; k++) begin
      bit wc = w && a == 5 && d[FPOS[k]];
      m_flag[k] = (m_flag[k] && !wc) || (hit[k] && m_ctrl[10+k]);
    end
    if (w && a == 0) m_ctrl = d & 16'h1C47;
    if (w && (a >= 1 && a <= 3)) m_cmp[a-1] = d;
    if (w && a == 6) for (int k = 0; k < 3; k++) m_mask[k] = d[FPOS[k]];
    m_cnt = n_cnt;
    @(negedge clk_i);
    tick_i = 0; wr_en_i = 0;
    chk("R11 irq per cycle", int'(irq_o), int'(m_irq()));
  endtask

  task automatic wr(input int a, input int d);
    cyc(0, 1, a, d);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0);
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    addr_i = 3'(a); wr_en_i = 0; tick_i = 0;
    #2;
    chk(tag, int'(rd_data_o), exp);
    chk({tag, " (model)"}, int'(rd_data_o), m_rd(a));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    bit [15:0] lfsr;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(0, 16'h0007, "R1 ctrl");
    rd(4, 0, "R1 counter");
    rd(5, 0, "R1 flags");
    rd(6, 0, "R1 mask");
    chk("R1 irq", int'(irq_o), 0);

    // R2 count, hold, wrap; R13 load
    ticks(5);
    rd(4, 5, "R2 count");
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    rd(4, 5, "R2 hold");
    wr(4, 16'hFFFE);
    rd(4, 16'hFFFE, "R13 load");
    ticks(1);
    rd(4, 16'hFFFF, "R2 step");
    ticks(1);
    rd(4, 0, "R2 wrap");
    cyc(1, 1, 4, 16'h0100);
    rd(4, 16'h0100, "R13 load over tick");

    // R3 compare 2 -> flag 11
    wr(3, 16'h0010);
    wr(0, 16'h1007);
    wr(4, 16'h000E);
    ticks(2);
    cyc(0, 0, 0, 0);
    rd(5, 16'h0800, "R3 flag11");
    chk("R11 irq on flag", int'(irq_o), 1);

    // R10 clear, R12 no re-set while timer holds
    wr(5, 16'h0800);
    rd(5, 0, "R10 w1c");
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    rd(5, 0, "R12 once per value");

    // R4 and set-wins
    wr(2, 16'h0020);
    wr(0, 16'h1807);
    wr(4, 16'h0020);
    wr(5, 16'h8000);
    rd(5, 16'h8000, "R10 set wins / R4 flag15");

    // R11 mask
    wr(6, 16'h8000);
    chk("R11 masked", int'(irq_o), 0);
    wr(6, 0);
    chk("R11 unmasked", int'(irq_o), 1);
    wr(5, 16'hC800);
    rd(5, 0, "R10 clear all");

    // R5, R8 clear on compare 0
    wr(1, 16'h0030);
    wr(0, 16'h0447);
    wr(4, 16'h002E);
    ticks(3);
    rd(4, 0, "R8 cleared");
    rd(5, 16'h4000, "R5 flag14");
    ticks(1);
    rd(4, 1, "R8 counts on");

    // R9 time-triggered guard
    wr(5, 16'h4000);
    wr(0, 16'h0443);
    wr(4, 16'h002F);
    ticks(2);
    rd(4, 16'h0031, "R9 no clear");

    // R6 disabled compares
    wr(0, 16'h0007);
    wr(5, 16'hC800);
    wr(4, 16'h000F);
    ticks(36);
    rd(4, 16'h0033, "R6 counter");
    rd(5, 0, "R6 no flags");

    // R7 reserved bits
    wr(0, 16'hFFFF);
    rd(0, 16'h1C47, "R7 ctrl readback");

    // mixed stimulus against the model
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      bit t, w;
      int a, d;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      t = lfsr[0] | lfsr[1];
      w = (lfsr[4:2] == 3'd0);
      a = int'(lfsr[7:5]) % 7;
      d = (a == 4 || a <= 3 && a >= 1) ? int'(lfsr[15:10]) : int'({lfsr[15:8], lfsr[7:0]});
      if (a == 0) d = d | 16'h1C00;
      cyc(t, w, a, d);
      rd(4, m_rd(4), "R2 mixed counter");
      rd(5, m_rd(5), "R10 mixed flags");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule